// File: doc/BRIEF.md
# Host-Bus Register Port with Access Lock

This block is the slave side of a 16-bit card-style host bus, as seen by a small register file. The host presents a word address, a data word, two active-low card-enable strobes that pick the byte lanes, and active-low read (output-enable) and write (write-enable) strobes. The block runs on a bus clock of its own, because the card bus does not provide one. It brings the strobes into that clock domain and holds the host off with an active-low wait signal for a fixed two clocks on every access. It then performs the write, or presents the read word for as long as the read strobe stays low.

Behind the port sits a file of sixteen 16-bit word registers. The low byte of word 0 is a fixed identification code. The high byte of word 0 is a control byte, and its top bit (word bit 15) is an access lock that is set by reset. While the lock is set, word 0 is the only register that can be reached. Reads of any other word return zero, and writes to any other word are dropped. Software opens the rest of the file by writing 0 to the lock bit. It can close the file again by writing 1, and the stored contents are kept. The reset input is active low, the inverse of the card's active-high reset. The block leaves reset on the first clock edge at which that input is sampled high.

Top module: `pcc_reg_port`

## Requirements
- R1: While reset is held and on the first clock after reset, the block drives `locked` = 1, `wait_n` = 1 and `host_doe` = 0. Word 0 then reads back 0x80 in its high byte.
- R2: The low byte of word 0 always reads back the identification code (default 0x5A), and writes to that byte have no effect.
- R3: While `locked` is 1, a read of any word other than word 0 returns 0x0000. A write to any such word leaves it unchanged, and the unchanged value can be seen once the lock is cleared.
- R4: A write that carries the high lane of word 0 with bit 15 = 0 clears `locked`. From the next access on, words 1 to 15 can be written and read back.
- R5: `ce_lo_n` low selects data bits 7:0 and `ce_hi_n` low selects bits 15:8. A write changes only the selected bytes. A read returns the selected bytes and zero in the bytes that are not selected.
- R6: Every access, read or write, pulls `wait_n` low for exactly two consecutive bus clocks and then releases it.
- R7: After `wait_n` is released on a read, `host_doe` is 1 and `host_dout` holds steady for as long as `oe_n` stays low. `host_doe` returns to 0 within five clocks after the strobes are released.
- R8: The register index is `host_addr[3:0]`. An address with any bit of `host_addr[19:4]` set reads 0x0000, and a write to such an address changes no register.
- R9: A reset that falls on the same clock edge as the completion of a write wins over the write. Afterwards, every word holds its reset value and `locked` is 1.
- R10: Writing 1 to bit 15 of word 0 sets `locked` again and hides words 1 to 15. Their contents are kept and read back unchanged once the lock is cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied to the block |
| rst_n | input | 1 | Active-low synchronous reset (inverse of card reset) |
| host_addr | input | 20 | Host word address (card address bits 20 to 1) |
| host_din | input | 16 | Write data from the host |
| host_dout | output | 16 | Read data to the host |
| host_doe | output | 1 | High while read data should be driven onto the bus |
| ce_lo_n | input | 1 | Active-low enable for data bits 7:0 |
| ce_hi_n | input | 1 | Active-low enable for data bits 15:8 |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| wait_n | output | 1 | Active-low cycle stretch to the host |
| locked | output | 1 | Current state of the access lock |

## Verification
A reset and the completion of a pending write can fall on the same bus-clock edge. The bench starts a write to word 3 after unlocking, counts the wait-low cycles as they happen, and pulls reset low just before the edge that would commit the data. The outcome is judged at the ports. `locked` must read 1 after reset, and once the lock is cleared again word 3 must read zero rather than the written value. A second overlap comes from a lock-bit write followed at once by an access to a hidden word. That access must see the new lock state.

// File: rtl/pcc_reg_pkg.sv
package pcc_reg_pkg;

    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int ADDR_W  = 20;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_DONE    = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*BYTE_W +: BYTE_W] = {BYTE_W{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/pcc_strobe_sync.sv
module pcc_strobe_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] active
);

    logic [N-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= strobe_n;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= '1;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign active = ~pipe[STAGES-1];

endmodule

// File: rtl/pcc_access_fsm.sv
module pcc_access_fsm
    import pcc_reg_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lo,
    input  logic              ce_hi,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output acc_req_t          req,
    output logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic              wait_n
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    acc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             bus_req;
    logic             finish;

    assign bus_req = (ce_lo | ce_hi) & (rd | wr);
    assign finish  = (state == ST_STRETCH) && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            req   <= '0;
            dout  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (bus_req) begin
                        req.addr  <= addr;
                        req.lanes <= {ce_hi, ce_lo};
                        req.write <= wr;
                        req.wdata <= wdata;
                        cnt       <= '0;
                        state     <= ST_STRETCH;
                    end
                end
                ST_STRETCH: begin
                    if (finish) begin
                        state <= ST_DONE;
                        if (!req.write) dout <= rd_word & lane_mask(req.lanes);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!bus_req) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_en  = finish && req.write;
    assign wait_n = (state != ST_STRETCH);
    assign doe    = (state == ST_DONE) && !req.write;

    // R6: the stretch never lasts beyond two clocks
    a_r6_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n && $past(!wait_n) && $past(rst_n)) |=> wait_n);

    // R6: the stretch never lasts a single clock
    a_r6_wait_two: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n && $past(wait_n) && $past(rst_n)) |=> !wait_n);

    // R7: read data is only driven once the host is released
    a_r7_doe_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> wait_n);

    // R7: read data is held while it is driven
    a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && $past(doe) && $past(rst_n)) |-> $stable(dout));

endmodule

// File: rtl/pcc_reg_file.sv
module pcc_reg_file
    import pcc_reg_pkg::*;
#(
    parameter int          REG_WORDS  = 16,
    parameter logic [7:0]  ID_CODE    = 8'h5A,
    parameter logic [7:0]  CTRL_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              locked
);

    localparam int IDX_W    = $clog2(REG_WORDS);
    localparam int LOCK_BIT = BYTE_W - 1;

    logic [BYTE_W-1:0] ctrl_q;
    logic [DATA_W-1:0] words [1:REG_WORDS-1];
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              visible;
    logic              ctrl_hit;

    assign idx      = addr[IDX_W-1:0];
    assign in_range = (addr[ADDR_W-1:IDX_W] == '0);
    assign locked   = ctrl_q[LOCK_BIT];
    assign visible  = in_range && ((idx == '0) || !locked);
    assign ctrl_hit = wr_en && visible && (idx == '0) && lanes[1];

    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= CTRL_RESET;
        else if (ctrl_hit) ctrl_q <= wdata[DATA_W-1:BYTE_W];
    end

    for (genvar w = 1; w < REG_WORDS; w++) begin : g_word
        logic hit;
        assign hit = wr_en && visible && (idx == IDX_W'(w));
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[w][b*BYTE_W +: BYTE_W] <= '0;
                else if (hit && lanes[b])
                    words[w][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        // R3: no hidden word moves while the lock is set
        a_r3_hidden_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && locked) |=> $stable(words[w]));

        // R8: writes outside the register range leave every word alone
        a_r8_range_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !in_range) |=> $stable(words[w]));
    end

    always_comb begin
        rd_word = '0;
        if (visible) begin
            if (idx == '0) rd_word = {ctrl_q, ID_CODE};
            for (int w = 1; w < REG_WORDS; w++) begin
                if (idx == IDX_W'(w)) rd_word = words[w];
            end
        end
    end

    // R1: reset always leaves the file locked
    a_r1_lock_reset: assert property (@(posedge clk)
        !rst_n |=> locked);

    // R4: the lock only changes as the result of a write
    a_r4_lock_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (locked != $past(locked))) |-> $past(wr_en));

    // R8: the control byte ignores out-of-range writes
    a_r8_ctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> $stable(ctrl_q));

endmodule

// File: rtl/pcc_reg_port.sv
module pcc_reg_port
    import pcc_reg_pkg::*;
#(
    parameter int         REG_WORDS   = 16,
    parameter int         WAIT_CYCLES = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_CODE     = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              ce_lo_n,
    input  logic              ce_hi_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              wait_n,
    output logic              locked
);

    logic [3:0]        act;
    acc_req_t          req;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;

    pcc_strobe_sync #(
        .N      (4),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({we_n, oe_n, ce_hi_n, ce_lo_n}),
        .active   (act)
    );

    pcc_access_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_lo   (act[0]),
        .ce_hi   (act[1]),
        .rd      (act[2]),
        .wr      (act[3]),
        .addr    (host_addr),
        .wdata   (host_din),
        .rd_word (rd_word),
        .req     (req),
        .wr_en   (wr_en),
        .dout    (host_dout),
        .doe     (host_doe),
        .wait_n  (wait_n)
    );

    pcc_reg_file #(
        .REG_WORDS  (REG_WORDS),
        .ID_CODE    (ID_CODE),
        .CTRL_RESET (8'h80)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (req.addr),
        .lanes   (req.lanes),
        .wr_en   (wr_en),
        .wdata   (req.wdata),
        .rd_word (rd_word),
        .locked  (locked)
    );

endmodule

// File: tb/pcc_reg_port_bench.sv
module pcc_reg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        host_doe;
    logic        ce_lo_n = 1'b1;
    logic        ce_hi_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic        wait_n;
    logic        locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam logic [7:0] ID = 8'h5A;

    pcc_reg_port u_pcc_reg_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .ce_lo_n(ce_lo_n),
        .ce_hi_n(ce_hi_n), .oe_n(oe_n), .we_n(we_n), .wait_n(wait_n), .locked(locked)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        ce_lo_n = 1'b1; ce_hi_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic access(input logic [19:0] a, input logic [1:0] ln, input logic wr,
                          input logic [15:0] d, input int hold, output logic [15:0] q);
        int n;
        int guard;
        @(negedge clk);
        host_addr = a; host_din = d;
        ce_lo_n = ~ln[0]; ce_hi_n = ~ln[1]; we_n = ~wr; oe_n = wr;
        guard = 0;
        while (wait_n && guard < 20) begin @(negedge clk); guard++; end
        n = 0;
        while (!wait_n && n < 20) begin @(negedge clk); n++; end
        check("R6 wait_n low length", n, 2);
        q = host_dout;
        if (!wr) begin
            check("R7 host_doe while oe_n low", host_doe, 1);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check("R7 host_dout held", host_dout, q);
            end
        end
        release_bus();
        repeat (5) @(negedge clk);
        if (!wr) check("R7 host_doe after release", host_doe, 0);
    endtask

    task automatic wr16(input logic [19:0] a, input logic [1:0] ln, input logic [15:0] d);
        logic [15:0] q;
        access(a, ln, 1'b1, d, 0, q);
    endtask

    task automatic rd16(input logic [19:0] a, input logic [1:0] ln, output logic [15:0] q);
        access(a, ln, 1'b0, 16'h0, 0, q);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 locked during reset", locked, 1);
        check("R1 wait_n during reset", wait_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] q;
        do_reset();
        check("R1 locked after reset", locked, 1);
        check("R1 wait_n idle", wait_n, 1);
        check("R1 host_doe idle", host_doe, 0);
        rd16(20'h0, 2'b11, q);
        check("R1 R2 word 0 after reset", q, {8'h80, ID});
    endtask

    task automatic t_locked();
        logic [15:0] q;
        wr16(20'h3, 2'b11, 16'h1234);
        rd16(20'h3, 2'b11, q);
        check("R3 hidden word reads zero", q, 16'h0000);
        wr16(20'h0, 2'b01, 16'h0055);
        rd16(20'h0, 2'b11, q);
        check("R2 id byte unchanged", q, {8'h80, ID});
        check("R2 write to id left lock", locked, 1);
    endtask

    task automatic t_unlock();
        logic [15:0] q;
        wr16(20'h0, 2'b10, 16'h0000);
        check("R4 lock cleared", locked, 0);
        rd16(20'h3, 2'b11, q);
        check("R3 discarded write not stored", q, 16'h0000);
        wr16(20'h3, 2'b11, 16'hA5C3);
        rd16(20'h3, 2'b11, q);
        check("R4 word 3 readback", q, 16'hA5C3);
        wr16(20'hF, 2'b11, 16'h0F0E);
        rd16(20'hF, 2'b11, q);
        check("R4 top word readback", q, 16'h0F0E);
    endtask

    task automatic t_lanes();
        logic [15:0] q;
        wr16(20'h5, 2'b11, 16'h1111);
        wr16(20'h5, 2'b01, 16'hFF22);
        rd16(20'h5, 2'b11, q);
        check("R5 low lane write", q, 16'h1122);
        wr16(20'h5, 2'b10, 16'h33FF);
        rd16(20'h5, 2'b11, q);
        check("R5 high lane write", q, 16'h3322);
        rd16(20'h5, 2'b01, q);
        check("R5 low lane read", q, 16'h0022);
        rd16(20'h5, 2'b10, q);
        check("R5 high lane read", q, 16'h3300);
    endtask

    task automatic t_range();
        logic [15:0] q;
        wr16(20'h00013, 2'b11, 16'hDEAD);
        rd16(20'h3, 2'b11, q);
        check("R8 aliased write ignored", q, 16'hA5C3);
        rd16(20'h00013, 2'b11, q);
        check("R8 out of range read", q, 16'h0000);
        wr16(20'h80000, 2'b10, 16'h8000);
        check("R8 out of range ctrl write", locked, 0);
    endtask

    task automatic t_hold();
        logic [15:0] q;
        access(20'h3, 2'b11, 1'b0, 16'h0, 6, q);
        check("R7 held read value", q, 16'hA5C3);
    endtask

    task automatic t_relock();
        logic [15:0] q;
        wr16(20'h0, 2'b10, 16'h8000);
        check("R10 lock set again", locked, 1);
        rd16(20'h3, 2'b11, q);
        check("R10 hidden after relock", q, 16'h0000);
        wr16(20'h0, 2'b10, 16'h0000);
        rd16(20'h3, 2'b11, q);
        check("R10 contents kept", q, 16'hA5C3);
    endtask

    task automatic t_reset_collide();
        logic [15:0] q;
        int guard;
        @(negedge clk);
        host_addr = 20'h3; host_din = 16'h0F0F;
        ce_lo_n = 1'b0; ce_hi_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        guard = 0;
        while (wait_n && guard < 20) begin @(negedge clk); guard++; end
        @(negedge clk);
        rst_n = 1'b0;
        release_bus();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 locked after colliding reset", locked, 1);
        wr16(20'h0, 2'b10, 16'h0000);
        rd16(20'h3, 2'b11, q);
        check("R9 reset beat the write", q, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_unlock();
        t_lanes();
        t_range();
        t_hold();
        t_relock();
        t_reset_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule